// File: doc/BRIEF.md
# Capacitive Sensing Stage Sequencer

This block runs the timing of one charge-averaging capacitive measurement. Either a software go request or an external event trigger starts a sequence. The sequence may open with a pre-charge stage, in which the internal hold capacitor is tied to a rail while the selected channel pin is driven to a digital level. It may then run an acquisition stage, in which the pin drivers are released and the channel shares charge with the hold capacitor. The sequence always ends in a conversion stage, which waits for an external conversion engine to report completion.

The lengths of the two opening stages are counted in instruction-cycle ticks that arrive on a tick-enable input. A length of zero removes that stage from the sequence. All control outputs are registered, and they match the stage reported on the status field. Deasserting the module enable returns the block to idle at once.

Top module: `cvd_seq_top`

## Requirements
- R1: After reset, `stage_o` is 2'b00 (idle), `go_o`, `conv_start_o` and `done_irq_o` are 0, and every drive output is 0.
- R2: While enabled and idle, a one-cycle pulse on `go_set_i` or `evt_trig_i` starts a sequence on the next clock edge. `stage_o` then encodes pre-charge as 2'b01, acquisition as 2'b10 and conversion as 2'b11, and the stages follow only that order. `go_o` is 1 exactly while `stage_o` is not 2'b00.
- R3: A non-zero `pre_len_i` keeps the pre-charge stage active for exactly that many `tick_i` pulses, counted at clock edges after the start edge. A value of 0 skips the stage.
- R4: During pre-charge, `hold_rail_o`=1, `hold_hi_o`=`int_pol_i`, `chan_conn_o`=0, `pin_ovr_o`=1, `pin_drv_en_o`=1 and `pin_lvl_o`=`ext_pol_i`.
- R5: During pre-charge, `aout_ovr_o` equals `aout_en_i`, and `aout_lvl_o` equals `int_pol_i` when that override is on and 0 otherwise. In every other stage, `aout_ovr_o` is 0.
- R6: A non-zero `acq_len_i` (the value latched at start) gives an acquisition stage of exactly that many ticks. It follows pre-charge, or follows the start edge directly when pre-charge is skipped. A value of 0 skips acquisition.
- R7: During acquisition, `pin_ovr_o`=1, `pin_drv_en_o`=0, `pin_lvl_o`=0, `chan_conn_o`=1, `hold_rail_o`=0 and `aout_ovr_o`=0.
- R8: `conv_start_o` is 1 only in the first cycle of the conversion stage. In idle and conversion, all drive outputs are 0.
- R9: In conversion, `conv_done_i` returns the block to idle on the next edge. On that edge `go_o` falls, `done_irq_o` pulses for one cycle and `result_o` captures `conv_result_i`.
- R10: With `en_i` low, the block is idle on the next edge, raises no `done_irq_o`, and ignores start pulses.
- R11: Start pulses that arrive while a sequence runs have no effect on the stage order or on stage lengths.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| en_i | input | 1 | Module enable |
| tick_i | input | 1 | Instruction-cycle tick enable |
| go_set_i | input | 1 | Software start pulse |
| evt_trig_i | input | 1 | External event start pulse |
| pre_len_i | input | LEN_W | Pre-charge length in ticks, 0 skips |
| acq_len_i | input | LEN_W | Acquisition length in ticks, 0 skips |
| int_pol_i | input | 1 | Hold capacitor rail select, 1 = supply |
| ext_pol_i | input | 1 | Channel pin drive level during pre-charge |
| aout_en_i | input | 1 | Enable analog-output pin override in pre-charge |
| conv_done_i | input | 1 | Conversion engine finished |
| conv_result_i | input | RES_W | Conversion result from engine |
| go_o | output | 1 | Sequence in progress |
| stage_o | output | 2 | Stage code |
| conv_start_o | output | 1 | One-cycle start to the conversion engine |
| hold_rail_o | output | 1 | Hold capacitor tied to a rail |
| hold_hi_o | output | 1 | Selected rail is supply |
| chan_conn_o | output | 1 | Channel connected to hold capacitor |
| pin_ovr_o | output | 1 | Channel pin override active |
| pin_drv_en_o | output | 1 | Channel pin digital driver enabled |
| pin_lvl_o | output | 1 | Channel pin drive level |
| aout_ovr_o | output | 1 | Analog-output pin override active |
| aout_lvl_o | output | 1 | Analog-output pin drive level |
| done_irq_o | output | 1 | One-cycle completion interrupt |
| result_o | output | RES_W | Latched conversion result |

## Verification
The bench sets the pre-charge and acquisition lengths to 0, to 1, to the maximum and to random values, and it sends ticks at irregular times. A counter that used the wrong limit, or that counted the start edge, would show a tick count one off from the field. A block that got a zero field wrong would show a stage that should be absent. Every cycle, the bench compares each drive output with the stage code. This catches pin drivers left on into acquisition, the analog-output level following the wrong polarity, and an override that leaks past pre-charge. Extra start pulses during acquisition, a start with the enable low, and an enable drop in mid pre-charge catch designs that restart, lengthen a stage, or raise a completion interrupt on abort.

// File: rtl/cvd_seq_pkg.sv
package cvd_seq_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'b00,
    ST_PRE  = 2'b01,
    ST_ACQ  = 2'b10,
    ST_CONV = 2'b11
  } stage_e;

  typedef struct packed {
    logic hold_rail;
    logic hold_hi;
    logic chan_conn;
    logic pin_ovr;
    logic pin_drv_en;
    logic pin_lvl;
    logic aout_ovr;
    logic aout_lvl;
  } drive_t;

  function automatic drive_t drive_for(stage_e st, logic ipol, logic epol, logic aen);
    drive_t d;
    d = '0;
    case (st)
      ST_PRE: begin
        d.hold_rail  = 1'b1;
        d.hold_hi    = ipol;
        d.pin_ovr    = 1'b1;
        d.pin_drv_en = 1'b1;
        d.pin_lvl    = epol;
        d.aout_ovr   = aen;
        d.aout_lvl   = aen & ipol;
      end
      ST_ACQ: begin
        d.pin_ovr   = 1'b1;
        d.chan_conn = 1'b1;
      end
      default: d = '0;
    endcase
    return d;
  endfunction

endpackage

// File: rtl/cvd_tick_cnt.sv
module cvd_tick_cnt #(
  parameter int LEN_W = 7
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load_i,
  input  logic [LEN_W-1:0] load_val_i,
  input  logic             tick_i,
  output logic             expire_o
);

  localparam logic [LEN_W-1:0] ONE = LEN_W'(1);

  logic [LEN_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
    end else if (load_i) begin
      cnt_q <= load_val_i;
    end else if (tick_i && cnt_q != '0) begin
      cnt_q <= cnt_q - ONE;
    end
  end

  // Last tick of the running stage
  assign expire_o = tick_i && (cnt_q == ONE);

endmodule

// File: rtl/cvd_seq_ctrl.sv
module cvd_seq_ctrl
  import cvd_seq_pkg::*;
#(
  parameter int LEN_W = 7
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en_i,
  input  logic             start_i,
  input  logic [LEN_W-1:0] pre_len_i,
  input  logic [LEN_W-1:0] acq_len_i,
  input  logic             expire_i,
  input  logic             conv_done_i,
  output stage_e           stage_q_o,
  output stage_e           stage_d_o,
  output logic             load_o,
  output logic [LEN_W-1:0] load_val_o
);

  stage_e           stage_q;
  stage_e           stage_d;
  logic [LEN_W-1:0] acq_q;

  always_comb begin
    stage_d    = stage_q;
    load_o     = 1'b0;
    load_val_o = pre_len_i;
    if (!en_i) begin
      stage_d = ST_IDLE;
    end else begin
      case (stage_q)
        ST_IDLE: begin
          if (start_i) begin
            if (pre_len_i != '0) begin
              stage_d    = ST_PRE;
              load_o     = 1'b1;
              load_val_o = pre_len_i;
            end else if (acq_len_i != '0) begin
              stage_d    = ST_ACQ;
              load_o     = 1'b1;
              load_val_o = acq_len_i;
            end else begin
              stage_d = ST_CONV;
            end
          end
        end
        ST_PRE: begin
          if (expire_i) begin
            if (acq_q != '0) begin
              stage_d    = ST_ACQ;
              load_o     = 1'b1;
              load_val_o = acq_q;
            end else begin
              stage_d = ST_CONV;
            end
          end
        end
        ST_ACQ: begin
          if (expire_i) stage_d = ST_CONV;
        end
        default: begin
          if (conv_done_i) stage_d = ST_IDLE;
        end
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      stage_q <= ST_IDLE;
      acq_q   <= '0;
    end else begin
      stage_q <= stage_d;
      if (stage_q == ST_IDLE && start_i) acq_q <= acq_len_i;
    end
  end

  assign stage_q_o = stage_q;
  assign stage_d_o = stage_d;

endmodule

// File: rtl/cvd_drive_reg.sv
module cvd_drive_reg
  import cvd_seq_pkg::*;
#(
  parameter int RES_W = 10
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en_i,
  input  stage_e           stage_q_i,
  input  stage_e           stage_d_i,
  input  logic             int_pol_i,
  input  logic             ext_pol_i,
  input  logic             aout_en_i,
  input  logic             conv_done_i,
  input  logic [RES_W-1:0] conv_result_i,
  output drive_t           drive_o,
  output logic             go_o,
  output logic             conv_start_o,
  output logic             done_irq_o,
  output logic [RES_W-1:0] result_o
);

  logic finish;
  assign finish = en_i && (stage_q_i == ST_CONV) && conv_done_i;

  always_ff @(posedge clk) begin
    if (rst) begin
      drive_o      <= '0;
      go_o         <= 1'b0;
      conv_start_o <= 1'b0;
      done_irq_o   <= 1'b0;
      result_o     <= '0;
    end else begin
      drive_o      <= drive_for(stage_d_i, int_pol_i, ext_pol_i, aout_en_i);
      go_o         <= (stage_d_i != ST_IDLE);
      conv_start_o <= (stage_d_i == ST_CONV) && (stage_q_i != ST_CONV);
      done_irq_o   <= finish;
      if (finish) result_o <= conv_result_i;
    end
  end

endmodule

// File: rtl/cvd_seq_top.sv
module cvd_seq_top
  import cvd_seq_pkg::*;
#(
  parameter int LEN_W = 7,
  parameter int RES_W = 10
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en_i,
  input  logic             tick_i,
  input  logic             go_set_i,
  input  logic             evt_trig_i,
  input  logic [LEN_W-1:0] pre_len_i,
  input  logic [LEN_W-1:0] acq_len_i,
  input  logic             int_pol_i,
  input  logic             ext_pol_i,
  input  logic             aout_en_i,
  input  logic             conv_done_i,
  input  logic [RES_W-1:0] conv_result_i,
  output logic             go_o,
  output logic [1:0]       stage_o,
  output logic             conv_start_o,
  output logic             hold_rail_o,
  output logic             hold_hi_o,
  output logic             chan_conn_o,
  output logic             pin_ovr_o,
  output logic             pin_drv_en_o,
  output logic             pin_lvl_o,
  output logic             aout_ovr_o,
  output logic             aout_lvl_o,
  output logic             done_irq_o,
  output logic [RES_W-1:0] result_o
);

  stage_e           stage_q;
  stage_e           stage_d;
  logic             load;
  logic [LEN_W-1:0] load_val;
  logic             expire;
  logic             start;
  drive_t           drv;

  assign start = go_set_i | evt_trig_i;

  cvd_tick_cnt #(.LEN_W(LEN_W)) u_cnt (
    .clk       (clk),
    .rst       (rst),
    .load_i    (load),
    .load_val_i(load_val),
    .tick_i    (tick_i),
    .expire_o  (expire)
  );

  cvd_seq_ctrl #(.LEN_W(LEN_W)) u_ctrl (
    .clk        (clk),
    .rst        (rst),
    .en_i       (en_i),
    .start_i    (start),
    .pre_len_i  (pre_len_i),
    .acq_len_i  (acq_len_i),
    .expire_i   (expire),
    .conv_done_i(conv_done_i),
    .stage_q_o  (stage_q),
    .stage_d_o  (stage_d),
    .load_o     (load),
    .load_val_o (load_val)
  );

  cvd_drive_reg #(.RES_W(RES_W)) u_drv (
    .clk          (clk),
    .rst          (rst),
    .en_i         (en_i),
    .stage_q_i    (stage_q),
    .stage_d_i    (stage_d),
    .int_pol_i    (int_pol_i),
    .ext_pol_i    (ext_pol_i),
    .aout_en_i    (aout_en_i),
    .conv_done_i  (conv_done_i),
    .conv_result_i(conv_result_i),
    .drive_o      (drv),
    .go_o         (go_o),
    .conv_start_o (conv_start_o),
    .done_irq_o   (done_irq_o),
    .result_o     (result_o)
  );

  assign stage_o      = stage_q;
  assign hold_rail_o  = drv.hold_rail;
  assign hold_hi_o    = drv.hold_hi;
  assign chan_conn_o  = drv.chan_conn;
  assign pin_ovr_o    = drv.pin_ovr;
  assign pin_drv_en_o = drv.pin_drv_en;
  assign pin_lvl_o    = drv.pin_lvl;
  assign aout_ovr_o   = drv.aout_ovr;
  assign aout_lvl_o   = drv.aout_lvl;

endmodule

// File: rtl/cvd_seq_chk.sv
module cvd_seq_chk (
  input logic       clk,
  input logic       rst,
  input logic       en_i,
  input logic       conv_done_i,
  input logic       go_o,
  input logic [1:0] stage_o,
  input logic       conv_start_o,
  input logic       hold_rail_o,
  input logic       hold_hi_o,
  input logic       chan_conn_o,
  input logic       pin_ovr_o,
  input logic       pin_drv_en_o,
  input logic       aout_ovr_o,
  input logic       aout_lvl_o,
  input logic       done_irq_o
);

  // R2
  go_tracks_stage_chk: assert property (@(posedge clk) disable iff (rst)
    go_o == (stage_o != 2'b00));

  // R2
  no_backstep_chk: assert property (@(posedge clk) disable iff (rst)
    (stage_o == 2'b10) |=> (stage_o != 2'b01));

  // R4
  pre_drive_chk: assert property (@(posedge clk) disable iff (rst)
    (stage_o == 2'b01) |-> (hold_rail_o && pin_drv_en_o && !chan_conn_o));

  // R5
  aout_level_chk: assert property (@(posedge clk) disable iff (rst)
    aout_ovr_o |-> (aout_lvl_o == hold_hi_o && stage_o == 2'b01));

  // R7
  acq_release_chk: assert property (@(posedge clk) disable iff (rst)
    (stage_o == 2'b10) |-> (pin_ovr_o && !pin_drv_en_o && chan_conn_o && !aout_ovr_o));

  // R8
  conv_start_stage_chk: assert property (@(posedge clk) disable iff (rst)
    conv_start_o |-> (stage_o == 2'b11));

  // R9
  irq_cause_chk: assert property (@(posedge clk) disable iff (rst)
    done_irq_o |-> ($past(stage_o) == 2'b11 && $past(conv_done_i) && $past(en_i)));

  // R10
  disable_idle_chk: assert property (@(posedge clk) disable iff (rst)
    !en_i |=> (stage_o == 2'b00 && !done_irq_o));

endmodule

bind cvd_seq_top cvd_seq_chk u_chk (
  .clk         (clk),
  .rst         (rst),
  .en_i        (en_i),
  .conv_done_i (conv_done_i),
  .go_o        (go_o),
  .stage_o     (stage_o),
  .conv_start_o(conv_start_o),
  .hold_rail_o (hold_rail_o),
  .hold_hi_o   (hold_hi_o),
  .chan_conn_o (chan_conn_o),
  .pin_ovr_o   (pin_ovr_o),
  .pin_drv_en_o(pin_drv_en_o),
  .aout_ovr_o  (aout_ovr_o),
  .aout_lvl_o  (aout_lvl_o),
  .done_irq_o  (done_irq_o)
);

// File: tb/cvd_seq_top_tb_top.sv
module cvd_seq_top_tb_top;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       en_i = 1'b1;
  logic       tick_i = 1'b0;
  logic       go_set_i = 1'b0;
  logic       evt_trig_i = 1'b0;
  logic [6:0] pre_len_i = '0;
  logic [6:0] acq_len_i = '0;
  logic       int_pol_i = 1'b0;
  logic       ext_pol_i = 1'b0;
  logic       aout_en_i = 1'b0;
  logic       conv_done_i = 1'b0;
  logic [9:0] conv_result_i = '0;
  logic       go_o, conv_start_o, hold_rail_o, hold_hi_o, chan_conn_o;
  logic       pin_ovr_o, pin_drv_en_o, pin_lvl_o, aout_ovr_o, aout_lvl_o, done_irq_o;
  logic [1:0] stage_o;
  logic [9:0] result_o;

  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  cvd_seq_top dut_i (
    .clk(clk), .rst(rst), .en_i(en_i), .tick_i(tick_i), .go_set_i(go_set_i),
    .evt_trig_i(evt_trig_i), .pre_len_i(pre_len_i), .acq_len_i(acq_len_i),
    .int_pol_i(int_pol_i), .ext_pol_i(ext_pol_i), .aout_en_i(aout_en_i),
    .conv_done_i(conv_done_i), .conv_result_i(conv_result_i), .go_o(go_o),
    .stage_o(stage_o), .conv_start_o(conv_start_o), .hold_rail_o(hold_rail_o),
    .hold_hi_o(hold_hi_o), .chan_conn_o(chan_conn_o), .pin_ovr_o(pin_ovr_o),
    .pin_drv_en_o(pin_drv_en_o), .pin_lvl_o(pin_lvl_o), .aout_ovr_o(aout_ovr_o),
    .aout_lvl_o(aout_lvl_o), .done_irq_o(done_irq_o), .result_o(result_o)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic logic [7:0] exp_drive(input logic [1:0] st, input logic ip,
                                           input logic ep, input logic ae);
    case (st)
      2'b01:   return {1'b1, ip, 1'b0, 1'b1, 1'b1, ep, ae, ae & ip};
      2'b10:   return 8'b0011_0000;
      default: return 8'b0;
    endcase
  endfunction

  function automatic logic [7:0] act_drive();
    return {hold_rail_o, hold_hi_o, chan_conn_o, pin_ovr_o,
            pin_drv_en_o, pin_lvl_o, aout_ovr_o, aout_lvl_o};
  endfunction

  function automatic string drive_req(input logic [1:0] st);
    case (st)
      2'b01:   return "R4 R5";
      2'b10:   return "R7";
      default: return "R8";
    endcase
  endfunction

  task automatic run_seq(input logic [6:0] pre, input logic [6:0] acq,
                         input bit use_evt, input bit poke);
    int pre_ticks = 0;
    int acq_ticks = 0;
    int conv_cyc = 0;
    bit seen_pre = 0;
    bit seen_acq = 0;
    bit finished = 0;
    logic [1:0] prev = 2'b00;
    logic [1:0] s;
    logic [1:0] first;
    logic [9:0] res = '0;
    pre_len_i = pre;
    acq_len_i = acq;
    int_pol_i = 1'($urandom);
    ext_pol_i = 1'($urandom);
    aout_en_i = 1'($urandom);
    @(negedge clk);
    if (use_evt) evt_trig_i = 1'b1; else go_set_i = 1'b1;
    tick_i = 1'($urandom);
    @(negedge clk);
    evt_trig_i = 1'b0;
    go_set_i = 1'b0;
    first = (pre != 0) ? 2'b01 : (acq != 0) ? 2'b10 : 2'b11;
    chk("R2 first stage", 32'(stage_o), 32'(first));
    chk("R2 go", 32'(go_o), 32'd1);
    for (int c = 0; c < 3000; c++) begin
      s = stage_o;
      go_set_i = 1'b0;
      chk(drive_req(s), 32'(act_drive()), 32'(exp_drive(s, int_pol_i, ext_pol_i, aout_en_i)));
      if (s < prev || s == 2'b00) chk("R2 order", 32'(s), 32'(prev));
      if (s == 2'b01) seen_pre = 1;
      if (s == 2'b10) seen_acq = 1;
      if (s == 2'b11) begin
        chk("R8 conv start", 32'(conv_start_o), 32'(prev != 2'b11));
        conv_cyc++;
      end
      tick_i = 1'($urandom);
      if (s == 2'b01 && tick_i) pre_ticks++;
      if (s == 2'b10 && tick_i) acq_ticks++;
      // R11: extra start while acquisition is running
      if (poke && s == 2'b10 && acq_ticks == 1) go_set_i = 1'b1;
      if (s == 2'b11 && conv_cyc == 3) begin
        res = 10'($urandom);
        conv_result_i = res;
        conv_done_i = 1'b1;
        finished = 1;
        break;
      end
      prev = s;
      @(negedge clk);
    end
    if (!finished) chk("R8 conversion reached", 32'd0, 32'd1);
    @(negedge clk);
    conv_done_i = 1'b0;
    chk("R9 idle", 32'(stage_o), 32'd0);
    chk("R9 go low", 32'(go_o), 32'd0);
    chk("R9 irq", 32'(done_irq_o), 32'd1);
    chk("R9 result", 32'(result_o), 32'(res));
    @(negedge clk);
    chk("R9 irq one cycle", 32'(done_irq_o), 32'd0);
    chk("R3 pre present", 32'(seen_pre), 32'(pre != 0));
    chk("R3 pre ticks", 32'(pre_ticks), 32'(pre));
    chk("R6 acq present", 32'(seen_acq), 32'(acq != 0));
    chk("R6 R11 acq ticks", 32'(acq_ticks), 32'(acq));
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1
    chk("R1 stage", 32'(stage_o), 32'd0);
    chk("R1 go", 32'(go_o), 32'd0);
    chk("R1 drive", 32'(act_drive()), 32'd0);
    chk("R1 irq", 32'(done_irq_o | conv_start_o), 32'd0);

    run_seq(7'd0, 7'd0, 1'b0, 1'b0);
    run_seq(7'd0, 7'd5, 1'b1, 1'b1);
    run_seq(7'd1, 7'd0, 1'b0, 1'b0);
    run_seq(7'd1, 7'd1, 1'b1, 1'b1);
    run_seq(7'd127, 7'd127, 1'b0, 1'b1);
    for (int i = 0; i < 40; i++)
      run_seq(7'($urandom), ($urandom_range(0, 3) == 0) ? 7'd0 : 7'($urandom),
              1'($urandom), 1'($urandom));

    // R10: start ignored while disabled
    en_i = 1'b0;
    @(negedge clk);
    go_set_i = 1'b1;
    evt_trig_i = 1'b1;
    @(negedge clk);
    go_set_i = 1'b0;
    evt_trig_i = 1'b0;
    chk("R10 start ignored", 32'(stage_o), 32'd0);
    chk("R10 go stays low", 32'(go_o), 32'd0);
    en_i = 1'b1;

    // R10: abort in pre-charge
    pre_len_i = 7'd20;
    acq_len_i = 7'd4;
    tick_i = 1'b1;
    go_set_i = 1'b1;
    @(negedge clk);
    go_set_i = 1'b0;
    repeat (5) @(negedge clk);
    chk("R10 running before abort", 32'(stage_o), 32'd1);
    en_i = 1'b0;
    @(negedge clk);
    chk("R10 halted", 32'(stage_o), 32'd0);
    chk("R10 go low", 32'(go_o), 32'd0);
    chk("R10 drive off", 32'(act_drive()), 32'd0);
    chk("R10 no irq", 32'(done_irq_o), 32'd0);
    en_i = 1'b1;
    tick_i = 1'b0;
    @(negedge clk);
    chk("R10 stays idle", 32'(stage_o), 32'd0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule